// File: doc/BRIEF.md
# Sub-Second Real-Time Counter with Wake Alarm

The block keeps time as a free-running binary count that advances once per `tick` strobe. With the default widths the count is 48 bits, of which the lowest 16 are a binary fraction of a second, so one whole second is a count of 0x10000. Software reaches the count, a 32-bit alarm and a control byte through a byte-wide register port. The serial host bus, the oscillator that produces `tick` and any calendar conversion all sit outside the block.

Count writes are gathered byte by byte and reach the counter together, so the counter never holds a half-written time. Count reads are frozen by the read of the lowest byte, so a six-byte read sequence returns one consistent value even while the counter keeps moving.

The alarm holds the whole-second part of a target count. When the alarm is enabled and the whole-second field of the counter first equals it, the block emits a single-cycle power-up request on `wake_pulse`. It does not raise an interrupt. The control byte also holds a set-once "time valid" flag that only a loss of backup power (`rst_n`) clears, an oscillator bypass select and a clock-output disable.

Top module: `subsec_rtc`

## Requirements
- R1: Each cycle with `tick` high and no top-byte load, the count increases by one, wrapping modulo 2^48 (0xFFFF_FFFF_FFFF + 1 = 0).
- R2: Writes to count addresses 0 to 4 (least significant byte at address 0) are held in staging and leave the count unchanged. A write to address 5 loads all six bytes into the count at once, and this load wins over a `tick` in the same cycle.
- R3: A read returns its data on `rdata` one cycle after `rd_en`. A read of address 0 returns the live low byte and freezes the whole count. Reads of addresses 1 to 5 return bytes of that frozen copy, even if the count has advanced since.
- R4: Addresses 6 to 9 hold the alarm, least significant byte first, and hold count bits 47:16. They read back what was written.
- R5: With control bit 2 set, `wake_pulse` is high for exactly one cycle: the first cycle in which count bits 47:16 equal the alarm. It stays low for the rest of the match.
- R6: With control bit 2 clear, a match never raises `wake_pulse`.
- R7: The control register is at address 10 and resets to 0x30. Bit 0 is set-once: writing 1 sets it, and writing 0 does not clear it. Only `rst_n` clears it.
- R8: Control bit 0 drives `time_valid`, bit 1 drives `osc_bypass` (1 = bypass) and bit 3 drives `clkout_off` (1 = 32 kHz output buffer off). Bits 1 to 7 are read/write.
- R9: Reads of addresses 11 to 15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; represents loss of backup power |
| tick | input | 1 | Count-advance strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after `rd_en` |
| time_valid | output | 1 | Set-once "clock has been set" flag |
| osc_bypass | output | 1 | Oscillator bypass select |
| clkout_off | output | 1 | Clock output buffer disable |
| wake_pulse | output | 1 | Single-cycle power-up request on alarm match |

## Verification
The bench builds the block with its default parameters: a 48-bit count, 16 fractional bits, four alarm bytes and a 4-bit address. With these values a full count wrap can be reached in a few ticks by preloading 0xFFFF_FFFF_FFFE. An alarm match can be reached by loading a count three ticks below a whole second, and the end of a match lies far away, so single-pulse behaviour is visible within a short window. Random loads, followed by random tick counts and frozen multi-byte reads, cover carries across every byte lane.

// File: rtl/subsec_rtc_pkg.sv
package subsec_rtc_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [7:0] CTRL_RESET = 8'h30;
   localparam int unsigned CTRL_VALID_BIT  = 0;
   localparam int unsigned CTRL_BYPASS_BIT = 1;
   localparam int unsigned CTRL_ALMEN_BIT  = 2;
   localparam int unsigned CTRL_CKOFF_BIT  = 3;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
   import subsec_rtc_pkg::*;
#(
   parameter int unsigned CNT_W  = 48,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  snap_o
);
   localparam int unsigned NB = CNT_W / BYTE_W;

   logic [7:0]       stage_q [NB-1];
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;
   logic             top_wr;

   assign top_wr = wr_en && (addr == ADDR_W'(NB-1));

   for (genvar i = 0; i < NB-1; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              stage_q[i] <= '0;
         else if (wr_en && addr == ADDR_W'(i))    stage_q[i] <= wdata;
      end
      assign load_val[i*BYTE_W +: BYTE_W] = stage_q[i];
   end
   assign load_val[CNT_W-1 -: BYTE_W] = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (top_wr) cnt_q <= load_val;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             snap_q <= '0;
      else if (rd_en && addr == '0)           snap_q <= cnt_q;
   end

   assign cnt_o  = cnt_q;
   assign snap_o = snap_q;

   a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !top_wr) |=> cnt_q == $past(cnt_q) + 1'b1);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !top_wr) |=> $stable(cnt_q));
   a_r2_top_load: assert property (@(posedge clk) disable iff (!rst_n)
      top_wr |=> cnt_q[CNT_W-1 -: BYTE_W] == $past(wdata));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
   import subsec_rtc_pkg::*;
#(
   parameter int unsigned CNT_W  = 48,
   parameter int unsigned FRAC_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              alm_en,
   output logic [CNT_W-FRAC_W-1:0] alarm_o,
   output logic              wake_o
);
   localparam int unsigned NB    = CNT_W / BYTE_W;
   localparam int unsigned SEC_W = CNT_W - FRAC_W;
   localparam int unsigned AB    = SEC_W / BYTE_W;

   logic [7:0] alm_q [AB];
   logic       match, match_q;

   for (genvar j = 0; j < AB; j++) begin : g_alm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  alm_q[j] <= '0;
         else if (wr_en && addr == ADDR_W'(NB + j))   alm_q[j] <= wdata;
      end
      assign alarm_o[j*BYTE_W +: BYTE_W] = alm_q[j];
   end

   assign match = (cnt_i[CNT_W-1:FRAC_W] == alarm_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b1;
      else        match_q <= match;
   end

   assign wake_o = alm_en && match && !match_q;

   a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);
   a_r5_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> cnt_i[CNT_W-1:FRAC_W] == alarm_o);
   a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_en |-> !wake_o);
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
   import subsec_rtc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CTRL_ADDR = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        ctrl_o
);
   logic [7:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_RESET;
      else if (wr_en && addr == ADDR_W'(CTRL_ADDR))
         ctrl_q <= {wdata[7:1], ctrl_q[CTRL_VALID_BIT] | wdata[0]};
   end

   assign ctrl_o = ctrl_q;

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CTRL_VALID_BIT] |=> ctrl_q[CTRL_VALID_BIT]);
endmodule

// File: rtl/subsec_rtc.sv
module subsec_rtc
   import subsec_rtc_pkg::*;
#(
   parameter int unsigned CNT_W  = 48,
   parameter int unsigned FRAC_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              time_valid,
   output logic              osc_bypass,
   output logic              clkout_off,
   output logic              wake_pulse
);
   localparam int unsigned NB        = CNT_W / BYTE_W;
   localparam int unsigned SEC_W     = CNT_W - FRAC_W;
   localparam int unsigned AB        = SEC_W / BYTE_W;
   localparam int unsigned CTRL_ADDR = NB + AB;

   initial begin
      if (CNT_W % BYTE_W != 0 || FRAC_W % BYTE_W != 0)
         $error("widths must be whole bytes");
      if (FRAC_W >= CNT_W)
         $error("fraction must be narrower than count");
      if (CTRL_ADDR + 1 > (1 << ADDR_W))
         $error("address space too small");
   end

   logic [CNT_W-1:0] cnt, snap;
   logic [SEC_W-1:0] alarm;
   logic [7:0]       ctrl;
   logic [7:0]       rd_next;
   logic [7:0]       rdata_q;

   rtc_counter #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .cnt_o(cnt), .snap_o(snap));

   rtc_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .ctrl_o(ctrl));

   rtc_alarm #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_alm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cnt_i(cnt), .alm_en(ctrl[CTRL_ALMEN_BIT]), .alarm_o(alarm),
      .wake_o(wake_pulse));

   always_comb begin
      rd_next = '0;
      if (addr == '0) rd_next = cnt[7:0];
      for (int i = 1; i < NB; i++)
         if (addr == ADDR_W'(i)) rd_next = snap[i*BYTE_W +: BYTE_W];
      for (int j = 0; j < AB; j++)
         if (addr == ADDR_W'(NB + j)) rd_next = alarm[j*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(CTRL_ADDR)) rd_next = ctrl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_next;
   end

   assign rdata      = rdata_q;
   assign time_valid = ctrl[CTRL_VALID_BIT];
   assign osc_bypass = ctrl[CTRL_BYPASS_BIT];
   assign clkout_off = ctrl[CTRL_CKOFF_BIT];

   a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata_q));
   a_r8_valid_out: assert property (@(posedge clk) disable iff (!rst_n)
      time_valid |=> time_valid);
endmodule

// File: tb/subsec_rtc_tb.sv
module subsec_rtc_tb;
   logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic time_valid, osc_bypass, clkout_off, wake_pulse;
   int tests = 0, fails = 0, wakes = 0;
   bit done = 0;

   subsec_rtc u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .time_valid(time_valid), .osc_bypass(osc_bypass),
      .clkout_off(clkout_off), .wake_pulse(wake_pulse));

   always #5 clk = ~clk;

   always @(negedge clk) if (rst_n && wake_pulse) wakes++;

   function automatic logic [47:0] add48(logic [47:0] v, int n);
      return v + 48'(n);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(int a, output logic [7:0] d);
      @(negedge clk); rd_en = 1; addr = 4'(a);
      @(negedge clk); rd_en = 0; d = rdata;
   endtask

   task automatic load(logic [47:0] v);
      for (int i = 0; i < 6; i++) wr(i, v[i*8 +: 8]);
   endtask

   task automatic rd_cnt(output logic [47:0] v);
      logic [7:0] b;
      for (int i = 0; i < 6; i++) begin rd(i, b); v[i*8 +: 8] = b; end
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
      end
      @(negedge clk); tick = 0;
   endtask

   initial begin
      logic [7:0] b;
      logic [47:0] v, r;
      int n, w0;
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      rd(10, b);
      check("R7 reset ctrl", b, 8'h30);
      check("R8 reset valid", time_valid, 0);
      check("R5 reset wake", wake_pulse, 0);
      rd_cnt(r);
      check("R1 reset count", r, 0);

      for (int i = 0; i < 5; i++) wr(i, 8'hA0 + 8'(i));
      rd_cnt(r);
      check("R2 staged not loaded", r, 0);
      wr(5, 8'hA5);
      rd_cnt(r);
      check("R2 load", r, 48'hA5A4_A3A2_A1A0);

      load(48'hFFFF_FFFF_FFFE);
      ticks(3);
      rd_cnt(r);
      check("R1 wrap", r, 48'h0000_0000_0001);

      load(48'h1234_5678_00FF);
      rd(0, b);
      check("R3 live low byte", b, 8'hFF);
      ticks(4);
      for (int i = 1; i < 6; i++) begin
         rd(i, b);
         v = 48'h1234_5678_00FF;
         check("R3 frozen byte", b, v[i*8 +: 8]);
      end
      rd_cnt(r);
      check("R3 refreshed", r, add48(48'h1234_5678_00FF, 4));

      for (int k = 0; k < 20; k++) begin
         v = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         if (k == 0) v = 48'h0000_FFFF_FFFF;
         n = $urandom_range(0, 20);
         load(v);
         if (n > 0) ticks(n);
         rd_cnt(r);
         check("R1 random advance", r, add48(v, n));
      end

      wr(6, 8'h44); wr(7, 8'h33); wr(8, 8'h22); wr(9, 8'h11);
      for (int j = 0; j < 4; j++) begin
         rd(6 + j, b);
         check("R4 alarm readback", b, 8'h44 - 8'(j) * 8'h11);
      end
      wr(10, 8'h05);
      check("R8 valid set", time_valid, 1);
      w0 = wakes;
      load(48'h1122_3344_0000 - 48'd3);
      ticks(8);
      check("R5 one wake pulse", wakes - w0, 1);
      ticks(5);
      check("R5 no repeat during match", wakes - w0, 1);

      wr(10, 8'h0A);
      check("R7 sticky bit0", time_valid, 1);
      check("R8 bypass", osc_bypass, 1);
      check("R8 clkout off", clkout_off, 1);
      rd(10, b);
      check("R7 ctrl readback", b, 8'h0B);
      w0 = wakes;
      load(48'h1122_3344_0000 - 48'd3);
      ticks(8);
      check("R6 disabled no wake", wakes - w0, 0);

      for (int a = 11; a < 16; a++) begin
         rd(a, b);
         check("R9 unmapped zero", b, 0);
      end
      done = 1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule